// File: doc/BRIEF.md
# Monochrome Glyph Expander

This block draws one character cell into a pixel framebuffer. A controller places a drawing packet in a word-addressed packet buffer and pulses `start`. The block reads the command word, two corner words and two colour words. It then walks a 1-bit-per-pixel bitmap held in the packet, one row at a time. Each bitmap bit becomes either a foreground pixel or a background pixel. The pixels go out through a single-pixel write port into consecutive framebuffer rows, starting at the decoded screen position.

Pixels are either 8-bit palette indices or 24-bit grey levels; `mode24` selects which. While the block draws, it keeps a bounding box of the screen area it has touched, so a display refresher can limit its update to that area. The box accumulates across commands and returns to empty only on reset.

Top module: `glyph_expander`

## Requirements
- R1: The block draws only when packet word 0 equals 0x00000A21. For any other value it writes no pixels, leaves the dirty box unchanged, and pulses `done` on the second cycle after `start`.
- R2: The corner words are packet words 13 (first) and 14 (second). A corner's x is bits 29:19 of the word, reduced modulo 1280. A corner's y is bits 12:3 of (word − 63), reduced modulo 1024.
- R3: The pixel count per row is x2 − x (second x minus first x). A count of 16 or more writes 16 pixels, and a count of zero or less writes none.
- R4: The 22 bitmap rows come in pairs from packet words 4 to 11, then 30 to 32. Row 2k uses bits 15:0 of its word and row 2k+1 uses bits 31:16. Within a row, bit j gives pixel j, counting from the left.
- R5: Pixel j of row r is written at address ((y + r) mod 1024) × 1280 + x + j, where x and y come from the first corner.
- R6: With `mode24` low, a set bit writes {16'h0, foreground word bits 7:0} and a clear bit writes {16'h0, background word bits 7:0}. The foreground is packet word 16 and the background is word 29.
- R7: With `mode24` high, the colour word's bits 23:16 select a grey level g: value 0 gives 0, value 7 gives 192, and any other value gives 255. The pixel written is {g, g, g}.
- R8: After reset the dirty box is x_lo=2047, x_hi=0, y_lo=1023, y_hi=0. A drawing command widens x to include both decoded corner x values. It widens y to include the wrapped row address of all 22 rows, even when the pixel count is zero.
- R9: Writes go one pixel per cycle, left to right, rows in order. Each row takes one setup cycle plus one cycle per pixel, so `done` rises 6 + 22 × (1 + count) cycles after `start`.
- R10: `busy` is high from the cycle after `start` until `done`. `done` is a single-cycle pulse with `busy` low. A `start` pulse while busy is ignored.
- R11: During and right after reset, `busy`, `done` and `fb_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin processing the packet (accepted when idle) |
| mode24 | input | 1 | 1 = 24-bit grey pixels, 0 = 8-bit index pixels |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| pkt_addr | output | PKT_AW | Packet word address |
| pkt_data | input | 32 | Packet word at `pkt_addr`, same cycle |
| fb_we | output | 1 | Framebuffer pixel write strobe |
| fb_addr | output | FB_AW | Framebuffer pixel index |
| fb_data | output | 24 | Pixel value |
| dirty_x_lo | output | 11 | Dirty box left edge |
| dirty_x_hi | output | 11 | Dirty box right edge |
| dirty_y_lo | output | 10 | Dirty box top edge |
| dirty_y_hi | output | 10 | Dirty box bottom edge |

## Verification
The bench builds the block with its defaults: a 1280 × 1024 screen, 16-pixel rows and 22 rows per cell. With these values, an 11-bit x field can exceed the screen width, so the modulo step on x is exercised. A top row near line 1023 makes the row addresses wrap back to line 0. Corner spacings below zero, at zero, at 16 and above 16 all fit within the x field.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  // Coordinate field geometry inside a corner word
  localparam int XW      = 11;
  localparam int YW      = 10;
  localparam int X_LSB   = 19;
  localparam int Y_LSB   = 3;
  localparam int Y_BIAS  = 63;

  // Command code and word positions inside the packet
  localparam logic [31:0] PUTC_CODE = 32'h0000_0A21;
  localparam int W_CMD     = 0;
  localparam int W_CORNER1 = 13;
  localparam int W_CORNER2 = 14;
  localparam int W_FGCOL   = 16;
  localparam int W_BGCOL   = 29;

  // Bitmap words: first run of pairs, then a second run
  localparam int BMP_BASE_A  = 4;
  localparam int BMP_PAIRS_A = 8;
  localparam int BMP_BASE_B  = 30;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_CRN1, ST_CRN2, ST_FGC, ST_BGC, ST_ROW, ST_PIX, ST_FIN
  } gx_state_e;
endpackage

// File: rtl/glyph_corner.sv
module glyph_corner import glyph_pkg::*; #(
  parameter int SCR_W = 1280,
  parameter int SCR_H = 1024
) (
  input  logic [31:0]   word,
  output logic [XW-1:0] pos_x,
  output logic [YW-1:0] pos_y
);
  logic [XW-1:0] xf;
  logic [YW-1:0] yf;
  logic [31:0]   unbiased;

  always_comb begin
    unbiased = word - 32'(Y_BIAS);
    xf = word[X_LSB +: XW];
    yf = unbiased[Y_LSB +: YW];
    // a field is below twice the screen size, one subtraction suffices
    pos_x = (32'(xf) >= 32'(SCR_W)) ? XW'(32'(xf) - 32'(SCR_W)) : xf;
    pos_y = (32'(yf) >= 32'(SCR_H)) ? YW'(32'(yf) - 32'(SCR_H)) : yf;
  end
endmodule

// File: rtl/glyph_shade.sv
module glyph_shade (
  input  logic        mode24,
  input  logic [31:0] colour,
  output logic [23:0] pixel
);
  logic [7:0] grey;

  always_comb begin
    unique case (colour[23:16])
      8'd0:    grey = 8'd0;
      8'd7:    grey = 8'd192;
      default: grey = 8'd255;
    endcase
    pixel = mode24 ? {grey, grey, grey} : {16'h0, colour[7:0]};
  end
endmodule

// File: rtl/glyph_dirty.sv
module glyph_dirty import glyph_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x_en,
  input  logic [XW-1:0] x_a,
  input  logic [XW-1:0] x_b,
  input  logic          y_en,
  input  logic [YW-1:0] y_v,
  output logic [XW-1:0] x_lo,
  output logic [XW-1:0] x_hi,
  output logic [YW-1:0] y_lo,
  output logic [YW-1:0] y_hi
);
  logic [XW-1:0] x_lo_d, x_hi_d;
  logic [YW-1:0] y_lo_d, y_hi_d;

  always_comb begin
    x_lo_d = x_lo;
    x_hi_d = x_hi;
    y_lo_d = y_lo;
    y_hi_d = y_hi;
    if (x_en) begin
      if (x_a < x_lo_d) x_lo_d = x_a;
      if (x_b < x_lo_d) x_lo_d = x_b;
      if (x_a > x_hi_d) x_hi_d = x_a;
      if (x_b > x_hi_d) x_hi_d = x_b;
    end
    if (y_en) begin
      if (y_v < y_lo_d) y_lo_d = y_v;
      if (y_v > y_hi_d) y_hi_d = y_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_lo <= '1;
      x_hi <= '0;
      y_lo <= '1;
      y_hi <= '0;
    end else begin
      if (x_en) begin
        x_lo <= x_lo_d;
        x_hi <= x_hi_d;
      end
      if (y_en) begin
        y_lo <= y_lo_d;
        y_hi <= y_hi_d;
      end
    end
  end
endmodule

// File: rtl/glyph_expander.sv
module glyph_expander import glyph_pkg::*; #(
  parameter int SCR_W     = 1280,
  parameter int SCR_H     = 1024,
  parameter int CELL_W    = 16,
  parameter int CELL_ROWS = 22,
  parameter int PKT_AW    = 6,
  parameter int FB_AW     = $clog2(SCR_W * SCR_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode24,
  output logic              busy,
  output logic              done,
  output logic [PKT_AW-1:0] pkt_addr,
  input  logic [31:0]       pkt_data,
  output logic              fb_we,
  output logic [FB_AW-1:0]  fb_addr,
  output logic [23:0]       fb_data,
  output logic [XW-1:0]     dirty_x_lo,
  output logic [XW-1:0]     dirty_x_hi,
  output logic [YW-1:0]     dirty_y_lo,
  output logic [YW-1:0]     dirty_y_hi
);
  localparam int CNT_W = $clog2(CELL_W + 1);
  localparam int COL_W = $clog2(CELL_W);
  localparam int ROW_W = $clog2(CELL_ROWS);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(CELL_ROWS - 1);

  gx_state_e          st_q, st_d;
  logic [XW-1:0]      cx_q, cx2_q;
  logic [YW-1:0]      cy_q;
  logic [31:0]        fg_q, bg_q;
  logic [ROW_W-1:0]   row_q, row_d;
  logic [COL_W-1:0]   col_q, col_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               ld_c1, ld_c2, ld_fg, ld_bg, ld_row, ld_col;

  logic [XW-1:0]      dec_x;
  logic [YW-1:0]      dec_y;
  logic signed [XW+1:0] span;
  logic [ROW_W-2:0]   pair;
  logic [YW:0]        ysum;
  logic [YW-1:0]      yrow;
  logic [CELL_W-1:0]  half;
  logic               pix_on;
  logic [1:0][31:0]   col_src;
  logic [1:0][23:0]   col_pix;

  glyph_corner #(.SCR_W(SCR_W), .SCR_H(SCR_H)) u_corner (
    .word(pkt_data), .pos_x(dec_x), .pos_y(dec_y)
  );

  // foreground shader at index 0, background at index 1
  assign col_src[0] = fg_q;
  assign col_src[1] = bg_q;
  for (genvar k = 0; k < 2; k++) begin : g_shade
    glyph_shade u_shade (.mode24(mode24), .colour(col_src[k]), .pixel(col_pix[k]));
  end

  // Geometry shared by address and dirty logic
  always_comb begin
    span = $signed({2'b00, dec_x}) - $signed({2'b00, cx_q});
    pair = row_q[ROW_W-1:1];
    ysum = {1'b0, cy_q} + (YW+1)'(row_q);
    yrow = (ysum >= (YW+1)'(SCR_H)) ? YW'(ysum - (YW+1)'(SCR_H)) : YW'(ysum);
    half = row_q[0] ? pkt_data[2*CELL_W-1:CELL_W] : pkt_data[CELL_W-1:0];
    pix_on = half[col_q];
  end

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    row_d  = row_q;
    col_d  = col_q;
    cnt_d  = cnt_q;
    ld_c1  = 1'b0;
    ld_c2  = 1'b0;
    ld_fg  = 1'b0;
    ld_bg  = 1'b0;
    ld_row = 1'b0;
    ld_col = 1'b0;
    pkt_addr = '0;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_CMD;
      ST_CMD: begin
        pkt_addr = PKT_AW'(W_CMD);
        st_d = (pkt_data == PUTC_CODE) ? ST_CRN1 : ST_FIN;
      end
      ST_CRN1: begin
        pkt_addr = PKT_AW'(W_CORNER1);
        ld_c1 = 1'b1;
        st_d = ST_CRN2;
      end
      ST_CRN2: begin
        pkt_addr = PKT_AW'(W_CORNER2);
        ld_c2 = 1'b1;
        if (span <= 0)                                cnt_d = '0;
        else if (span > $signed((XW+2)'(CELL_W)))     cnt_d = CNT_W'(CELL_W);
        else                                          cnt_d = CNT_W'(span);
        st_d = ST_FGC;
      end
      ST_FGC: begin
        pkt_addr = PKT_AW'(W_FGCOL);
        ld_fg = 1'b1;
        st_d = ST_BGC;
      end
      ST_BGC: begin
        pkt_addr = PKT_AW'(W_BGCOL);
        ld_bg  = 1'b1;
        ld_row = 1'b1;
        row_d  = '0;
        st_d   = ST_ROW;
      end
      ST_ROW, ST_PIX: begin
        pkt_addr = (32'(pair) < BMP_PAIRS_A) ?
                   PKT_AW'(BMP_BASE_A + 32'(pair)) :
                   PKT_AW'(BMP_BASE_B + 32'(pair) - BMP_PAIRS_A);
        if (st_q == ST_ROW) begin
          ld_col = 1'b1;
          col_d  = '0;
          if (cnt_q != '0) st_d = ST_PIX;
          else if (row_q == LAST_ROW) st_d = ST_FIN;
          else begin
            ld_row = 1'b1;
            row_d  = row_q + 1'b1;
          end
        end else begin
          ld_col = 1'b1;
          col_d  = col_q + 1'b1;
          if (col_q == COL_W'(cnt_q - CNT_W'(1))) begin
            if (row_q == LAST_ROW) st_d = ST_FIN;
            else begin
              ld_row = 1'b1;
              row_d  = row_q + 1'b1;
              st_d   = ST_ROW;
            end
          end
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cx_q  <= '0;
      cy_q  <= '0;
      cx2_q <= '0;
      fg_q  <= '0;
      bg_q  <= '0;
      row_q <= '0;
      col_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (ld_c1) begin
        cx_q <= dec_x;
        cy_q <= dec_y;
      end
      if (ld_c2) begin
        cx2_q <= dec_x;
        cnt_q <= cnt_d;
      end
      if (ld_fg)  fg_q  <= pkt_data;
      if (ld_bg)  bg_q  <= pkt_data;
      if (ld_row) row_q <= row_d;
      if (ld_col) col_q <= col_d;
    end
  end

  glyph_dirty u_dirty (
    .clk(clk), .rst_n(rst_n),
    .x_en(st_q == ST_FGC), .x_a(cx_q), .x_b(cx2_q),
    .y_en(st_q == ST_ROW), .y_v(yrow),
    .x_lo(dirty_x_lo), .x_hi(dirty_x_hi),
    .y_lo(dirty_y_lo), .y_hi(dirty_y_hi)
  );

  assign busy    = (st_q != ST_IDLE) && (st_q != ST_FIN);
  assign done    = (st_q == ST_FIN);
  assign fb_we   = (st_q == ST_PIX);
  assign fb_addr = FB_AW'(yrow) * FB_AW'(SCR_W) + FB_AW'(cx_q) + FB_AW'(col_q);
  assign fb_data = pix_on ? col_pix[0] : col_pix[1];
endmodule

// File: rtl/glyph_expander_chk.sv
module glyph_expander_chk #(
  parameter int SCR_W = 1280,
  parameter int SCR_H = 1024,
  parameter int FB_AW = $clog2(SCR_W * SCR_H)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             mode24,
  input logic             busy,
  input logic             done,
  input logic             fb_we,
  input logic [FB_AW-1:0] fb_addr,
  input logic [23:0]      fb_data,
  input logic [10:0]      dirty_x_lo,
  input logic [10:0]      dirty_x_hi,
  input logic [9:0]       dirty_y_lo,
  input logic [9:0]       dirty_y_hi
);
  // R10: done lasts a single cycle
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: idle start leads to busy
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> busy);

  // R10: done and busy never overlap
  p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: pixel writes happen only inside a command
  p_write_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> busy);

  // R9: back-to-back writes move one pixel to the right
  p_write_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_we && $past(fb_we)) |-> (fb_addr == $past(fb_addr) + 1'b1));

  // R7: a 24-bit pixel is one of the three grey levels
  p_grey_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_we && mode24) |-> ((fb_data == 24'h000000) || (fb_data == 24'hC0C0C0) ||
                           (fb_data == 24'hFFFFFF)));

  // R6: an 8-bit pixel leaves the upper bytes clear
  p_index_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_we && !mode24) |-> (fb_data[23:8] == 16'h0));

  // R8: the dirty box only grows
  p_dirty_grow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_x_lo <= $past(dirty_x_lo)) && (dirty_x_hi >= $past(dirty_x_hi)) &&
    (dirty_y_lo <= $past(dirty_y_lo)) && (dirty_y_hi >= $past(dirty_y_hi)));
endmodule

bind glyph_expander glyph_expander_chk u_glyph_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode24(mode24), .busy(busy),
  .done(done), .fb_we(fb_we), .fb_addr(fb_addr), .fb_data(fb_data),
  .dirty_x_lo(dirty_x_lo), .dirty_x_hi(dirty_x_hi),
  .dirty_y_lo(dirty_y_lo), .dirty_y_hi(dirty_y_hi)
);

// File: tb/test_glyph_expander.sv
module test_glyph_expander;
  localparam int FB_AW = 21;

  logic clk, rst_n, start, mode24;
  logic busy, done, fb_we;
  logic [5:0]       pkt_addr;
  logic [31:0]      pkt_data;
  logic [FB_AW-1:0] fb_addr;
  logic [23:0]      fb_data;
  logic [10:0]      dirty_x_lo, dirty_x_hi;
  logic [9:0]       dirty_y_lo, dirty_y_hi;

  logic [31:0] pkt [64];
  assign pkt_data = pkt[pkt_addr];

  glyph_expander i_glyph_expander (
    .clk(clk), .rst_n(rst_n), .start(start), .mode24(mode24),
    .busy(busy), .done(done), .pkt_addr(pkt_addr), .pkt_data(pkt_data),
    .fb_we(fb_we), .fb_addr(fb_addr), .fb_data(fb_data),
    .dirty_x_lo(dirty_x_lo), .dirty_x_hi(dirty_x_hi),
    .dirty_y_lo(dirty_y_lo), .dirty_y_hi(dirty_y_hi)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks, failures;
  int exp_addr [352];
  int exp_data [352];
  int exp_n, exp_cycles;
  int m_xlo, m_xhi, m_ylo, m_yhi;
  int wi;
  bit mis;
  int mis_a, mis_d, mis_ea, mis_ed;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int fx(input logic [31:0] w);
    int v = int'(w[29:19]);
    return (v >= 1280) ? v - 1280 : v;
  endfunction

  function automatic int fy(input logic [31:0] w);
    logic [31:0] u = w - 32'd63;
    return int'(u[12:3]) % 1024;
  endfunction

  function automatic int shade(input logic [31:0] c, input bit m24);
    int g;
    if (!m24) return int'(c[7:0]);
    g = (c[23:16] == 8'd0) ? 0 : (c[23:16] == 8'd7) ? 192 : 255;
    return (g << 16) | (g << 8) | g;
  endfunction

  function automatic logic [31:0] mk_corner(input int x, input int y);
    return (32'(x) << 19) | ((32'(y) << 3) + 32'd63);
  endfunction

  // Expected pixel stream, cycle count and dirty box (R2..R9)
  task automatic build_expect(input bit m24);
    int x, y, x2, cnt, wd, yr;
    logic [15:0] half;
    exp_n = 0;
    if (pkt[0] != 32'h0000_0A21) begin
      exp_cycles = 2;
      return;
    end
    x = fx(pkt[13]); y = fy(pkt[13]); x2 = fx(pkt[14]);
    cnt = x2 - x;
    if (cnt < 0) cnt = 0;
    if (cnt > 16) cnt = 16;
    exp_cycles = 6 + 22 * (1 + cnt);
    if (x < m_xlo) m_xlo = x;
    if (x2 < m_xlo) m_xlo = x2;
    if (x > m_xhi) m_xhi = x;
    if (x2 > m_xhi) m_xhi = x2;
    for (int r = 0; r < 22; r++) begin
      wd = (r / 2 < 8) ? 4 + r / 2 : 22 + r / 2;
      half = (r % 2 == 1) ? pkt[wd][31:16] : pkt[wd][15:0];
      yr = (y + r) % 1024;
      if (yr < m_ylo) m_ylo = yr;
      if (yr > m_yhi) m_yhi = yr;
      for (int c = 0; c < cnt; c++) begin
        exp_addr[exp_n] = yr * 1280 + x + c;
        exp_data[exp_n] = half[c] ? shade(pkt[16], m24) : shade(pkt[29], m24);
        exp_n++;
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && fb_we) begin
      if (!(wi < exp_n && int'(fb_addr) == exp_addr[wi] && int'(fb_data) == exp_data[wi])
          && !mis) begin
        mis = 1'b1;
        mis_a = int'(fb_addr); mis_d = int'(fb_data);
        mis_ea = (wi < exp_n) ? exp_addr[wi] : -1;
        mis_ed = (wi < exp_n) ? exp_data[wi] : -1;
      end
      wi++;
    end
  end

  task automatic run_cmd(input bit m24, input bit poke, input string tag);
    int k;
    build_expect(m24);
    wi = 0; mis = 1'b0;
    mode24 = m24;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    k = 1;
    check(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    while (!done && k < 2000) begin
      @(negedge clk);
      k++;
      if (poke) start = (k == 10);
    end
    start = 1'b0;
    check(k == exp_cycles, "R9 cycles to done", k, exp_cycles);
    if (mis) $display("FAIL %s pixel addr/data actual=%0d/%0h expected=%0d/%0h",
                      tag, mis_a, mis_d, mis_ea, mis_ed);
    checks++;
    if (mis) failures++;
    check(wi == exp_n, "R3 pixel count", wi, exp_n);
    @(negedge clk);
    check(!done && !busy, "R10 done single pulse", int'(done), 0);
    check(int'(dirty_x_lo) == m_xlo && int'(dirty_x_hi) == m_xhi, "R8 dirty x",
          int'(dirty_x_lo) * 4096 + int'(dirty_x_hi), m_xlo * 4096 + m_xhi);
    check(int'(dirty_y_lo) == m_ylo && int'(dirty_y_hi) == m_yhi, "R8 dirty y",
          int'(dirty_y_lo) * 4096 + int'(dirty_y_hi), m_ylo * 4096 + m_yhi);
    repeat (2) @(negedge clk);
  endtask

  task automatic fill_pkt(input int x, input int y, input int x2,
                          input logic [31:0] fg, input logic [31:0] bg);
    for (int i = 0; i < 64; i++) pkt[i] = $urandom;
    pkt[0]  = 32'h0000_0A21;
    pkt[13] = mk_corner(x, y);
    pkt[14] = mk_corner(x2, 5);
    pkt[16] = fg;
    pkt[29] = bg;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0; wi = 0; mis = 1'b0; exp_n = 0;
    m_xlo = 2047; m_xhi = 0; m_ylo = 1023; m_yhi = 0;
    void'($urandom(32'd2718));
    start = 1'b0; mode24 = 1'b0; rst_n = 1'b0;
    for (int i = 0; i < 64; i++) pkt[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R11: outputs quiet in reset
    check(!busy && !done && !fb_we, "R11 reset outputs", int'({busy, done, fb_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !fb_we, "R11 after reset", int'({busy, done, fb_we}), 0);
    check(dirty_x_lo == 11'd2047 && dirty_x_hi == 11'd0, "R8 reset dirty x",
          int'(dirty_x_lo), 2047);
    check(dirty_y_lo == 10'd1023 && dirty_y_hi == 10'd0, "R8 reset dirty y",
          int'(dirty_y_lo), 1023);

    // R1: other command codes draw nothing
    fill_pkt(100, 50, 110, 32'h11, 32'h22);
    pkt[0] = 32'h0000_0A20;
    run_cmd(1'b0, 1'b0, "R1");
    // R6 / R4: 8-bit index colours
    fill_pkt(100, 50, 110, 32'h0000_00A5, 32'h0000_003C);
    run_cmd(1'b0, 1'b0, "R6 R4");
    // R7: grey 192 and 0
    fill_pkt(300, 200, 316, 32'h0007_0000, 32'h0000_00FF);
    run_cmd(1'b1, 1'b0, "R7");
    // R7: other level gives 255
    fill_pkt(300, 200, 312, 32'h0055_0000, 32'h0007_1234);
    run_cmd(1'b1, 1'b0, "R7");
    // R3: clamp to 16, zero, negative
    fill_pkt(200, 400, 240, 32'h1, 32'h2);
    run_cmd(1'b0, 1'b0, "R3");
    fill_pkt(500, 600, 500, 32'h1, 32'h2);
    run_cmd(1'b0, 1'b0, "R3");
    fill_pkt(700, 10, 690, 32'h1, 32'h2);
    run_cmd(1'b0, 1'b0, "R3");
    // R5: rows wrap past the bottom line
    fill_pkt(40, 1015, 47, 32'h3, 32'h4);
    run_cmd(1'b0, 1'b0, "R5");
    // R2: x fields beyond the screen width
    fill_pkt(1300, 20, 1310, 32'h5, 32'h6);
    run_cmd(1'b0, 1'b0, "R2");
    // R10: start while busy is ignored
    fill_pkt(800, 300, 805, 32'h7, 32'h8);
    run_cmd(1'b1, 1'b1, "R10");

    // Random packets with corner spacing near the row width
    for (int t = 0; t < 12; t++) begin
      int xa, d;
      xa = int'($urandom_range(0, 2047));
      d  = int'($urandom_range(0, 24)) - 4;
      for (int i = 0; i < 64; i++) pkt[i] = $urandom;
      pkt[0] = 32'h0000_0A21;
      pkt[13][29:19] = 11'(xa);
      pkt[14][29:19] = 11'(xa + d);
      run_cmd(1'($urandom_range(0, 1)), 1'b0, "R2 R4 R5");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule